// File: doc/BRIEF.md
# Counter Bit-Transition Event Stream

This block turns a free-running 64-bit count into a sparse stream of single-cycle event pulses. Software picks one bit of the count and a direction. A pulse is produced each time that bit moves to the chosen level. Typical uses are periodic wake-up events and a coarse timebase tick. A chip usually instantiates it twice, once on the physical count and once on the offset (virtual) count.

The count may advance by more than one per clock, so the chosen bit can skip a visible edge. For that reason the block never watches the bit itself. When it arms, and after every event, it computes the absolute count value at which the next transition lands. It then compares the live count against that target with a greater-or-equal test. The target holds one carry bit beyond the count width, so a transition past the top of the count range stays out of reach.

Top module: `evs_event_stream`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `evt_o` is low.
- R2: With `dir_i` = 1, the bit at index `bit_sel_i` is watched for a 0-to-1 change. When that bit is currently 0, the target is the count with every bit below the index cleared, plus 2^index.
- R3: When the watched bit already equals `dir_i`, the increment added to the cleared count is 2^(index+1) rather than 2^index.
- R4: With `dir_i` = 0, events mark 1-to-0 changes of the watched bit. The same target rule applies with the level 0.
- R5: Suppose that at a rising clock edge the block is armed, its configuration is unchanged, and the sampled count is greater than or equal to the target. Then `evt_o` is high for exactly the next cycle, and the new target is computed from that sampled count.
- R6: A count that jumps over several target values in one step yields one pulse, not one per skipped transition.
- R7: At the edge where `en_i` is first seen high, the target is computed from the sampled count and no event is produced at that edge.
- R8: At an edge where, while enabled, `bit_sel_i` or `dir_i` differs from the value used for the current target, the target is recomputed and no event is produced at that edge.
- R9: At an edge where `en_i` is low, no event is produced, and the block disarms.
- R10: A target that lies at or above 2^64 never produces an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cnt_i | input | 64 | Count value to watch |
| en_i | input | 1 | Stream enable |
| bit_sel_i | input | 6 | Index of the watched count bit |
| dir_i | input | 1 | 1: event on 0-to-1 change, 0: event on 1-to-0 change |
| evt_o | output | 1 | Single-cycle event pulse, registered |

## Verification
A wrong stored target shows up within one transition period of the watched bit. The pulse then arrives early or late, or stops arriving, when measured against the arithmetic target. A stale configuration copy shows up at the first edge after a change of index or direction: a spurious pulse appears, or the next pulse is misplaced. A lost armed state shows up as a pulse at the edge of enabling. The sweeps walk every index of the small range in both directions, one count step at a time. Each step is compared, so any of these faults appears at the port in the cycle it occurs.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EVS_CNT_W = 64;

  typedef enum logic {
    EVS_FALL = 1'b0,
    EVS_RISE = 1'b1
  } evs_dir_e;
endpackage

// File: rtl/evs_target_calc.sv
module evs_target_calc #(
  parameter int CNT_W = evs_pkg::EVS_CNT_W,
  localparam int SEL_W = $clog2(CNT_W)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  output logic [CNT_W:0]   tgt_o
);
  logic [CNT_W-1:0] keep;
  logic [CNT_W:0]   step_one;
  logic [CNT_W:0]   step;
  logic             at_level;

  // keep the watched bit and everything above it
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_keep
    assign keep[gi] = (SEL_W'(gi) >= sel_i);
  end

  always_comb begin
    at_level = (cnt_i[sel_i] == dir_i);
    step_one = (CNT_W+1)'(1) << sel_i;
    step     = at_level ? (step_one << 1) : step_one;
    tgt_o    = {1'b0, cnt_i & keep} + step;
  end
endmodule

// File: rtl/evs_reach_cmp.sv
module evs_reach_cmp #(
  parameter int CNT_W = evs_pkg::EVS_CNT_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   tgt_i,
  output logic             hit_o
);
  // extended width: a target carrying out of the count is never reached
  assign hit_o = ({1'b0, cnt_i} >= tgt_i);
endmodule

// File: rtl/evs_ctrl.sv
module evs_ctrl #(
  parameter int CNT_W = evs_pkg::EVS_CNT_W,
  localparam int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  input  logic [CNT_W:0]   tgt_new_i,
  input  logic             hit_i,
  output logic [CNT_W:0]   tgt_o,
  output logic             evt_o
);
  logic             armed_q, armed_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             dir_q, dir_d;
  logic [CNT_W:0]   tgt_q, tgt_d;
  logic             evt_q, evt_d;
  logic             cfg_chg;
  logic             st_we;

  always_comb begin
    cfg_chg = (sel_i != sel_q) || (dir_i != dir_q);
    armed_d = armed_q;
    sel_d   = sel_q;
    dir_d   = dir_q;
    tgt_d   = tgt_q;
    evt_d   = 1'b0;
    if (!en_i) begin
      armed_d = 1'b0;
    end else if (!armed_q || cfg_chg) begin
      armed_d = 1'b1;
      sel_d   = sel_i;
      dir_d   = dir_i;
      tgt_d   = tgt_new_i;
    end else if (hit_i) begin
      evt_d   = 1'b1;
      tgt_d   = tgt_new_i;
    end
    st_we = en_i | armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
      dir_q   <= 1'b0;
      tgt_q   <= '0;
    end else if (st_we) begin
      armed_q <= armed_d;
      sel_q   <= sel_d;
      dir_q   <= dir_d;
      tgt_q   <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign tgt_o = tgt_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/evs_event_stream.sv
module evs_event_stream #(
  parameter int CNT_W = evs_pkg::EVS_CNT_W,
  localparam int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             dir_i,
  output logic             evt_o
);
  logic [CNT_W:0] tgt_new;
  logic [CNT_W:0] tgt_cur;
  logic           hit;

  evs_target_calc #(.CNT_W(CNT_W)) u_calc (
    .cnt_i (cnt_i),
    .sel_i (bit_sel_i),
    .dir_i (dir_i),
    .tgt_o (tgt_new)
  );

  evs_reach_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i (cnt_i),
    .tgt_i (tgt_cur),
    .hit_o (hit)
  );

  evs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .sel_i     (bit_sel_i),
    .dir_i     (dir_i),
    .tgt_new_i (tgt_new),
    .hit_i     (hit),
    .tgt_o     (tgt_cur),
    .evt_o     (evt_o)
  );
endmodule

// File: rtl/evs_event_stream_chk.sv
module evs_event_stream_chk #(
  parameter int CNT_W = evs_pkg::EVS_CNT_W,
  localparam int SEL_W = $clog2(CNT_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             en_i,
  input logic [SEL_W-1:0] bit_sel_i,
  input logic             dir_i,
  input logic             evt_o
);
  // R9: a pulse needs the enable at the edge that produced it
  p_evt_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(en_i));

  // R7: the enabling edge arms only
  p_arm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |=> !evt_o);

  // R8: a configuration change while enabled arms only
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) &&
     ((bit_sel_i != $past(bit_sel_i)) || (dir_i != $past(dir_i)))) |=> !evt_o);

  // R5: after a pulse the new target lies beyond the count that caused it
  p_target_ahead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && en_i && (cnt_i == $past(cnt_i)) &&
     $stable(bit_sel_i) && $stable(dir_i)) |=> !evt_o);

  // R1: quiet right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !evt_o);
endmodule

bind evs_event_stream evs_event_stream_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .en_i      (en_i),
  .bit_sel_i (bit_sel_i),
  .dir_i     (dir_i),
  .evt_o     (evt_o)
);

// File: tb/evs_event_stream_tb.sv
module evs_event_stream_tb_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] cnt;
  logic        en;
  logic [5:0]  sel;
  logic        dir;
  logic        evt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  evs_event_stream dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt),
    .en_i      (en),
    .bit_sel_i (sel),
    .dir_i     (dir),
    .evt_o     (evt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [64:0] exp_tgt(logic [63:0] c, int idx, bit d);
    logic [64:0] base;
    logic [64:0] inc;
    base = {1'b0, (c >> idx) << idx};
    inc  = 65'd1 << idx;
    if (c[idx] == d) inc = inc << 1;
    return base + inc;
  endfunction

  task automatic chk(bit act, bit expv, string req);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: evt_o=%0b expected %0b (cnt=%h sel=%0d dir=%0b)",
               req, act, expv, cnt, sel, dir);
    end
  endtask

  // arm at start, then step the count and compare each cycle
  task automatic run_case(int idx, bit d, logic [63:0] start,
                          logic [63:0] stp, int n, string req);
    logic [64:0] t;
    bit          e;
    @(negedge clk); en = 1'b0; sel = 6'(idx); dir = d; cnt = start;
    @(negedge clk); en = 1'b1;
    t = exp_tgt(start, idx, d);
    @(negedge clk); chk(evt, 1'b0, "R7");
    for (int k = 0; k < n; k++) begin
      cnt = cnt + stp;
      e = ({1'b0, cnt} >= t);
      if (e) t = exp_tgt(cnt, idx, d);
      @(negedge clk); chk(evt, e, req);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; sel = '0; dir = 1'b1; cnt = '0;
    repeat (3) @(negedge clk);
    chk(evt, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk); chk(evt, 1'b0, "R1");

    // R2 R3 R4 R5: every small index, both directions, unit steps
    for (int idx = 0; idx < 6; idx++) begin
      for (int d = 0; d < 2; d++) begin
        run_case(idx, bit'(d), 64'd0, 64'd1, (4 << idx) + 6,
                 d ? "R2_R3_R5" : "R4_R5");
        run_case(idx, bit'(d), 64'h0123_4567_89AB_CDEF, 64'd1, (4 << idx) + 6,
                 d ? "R2_R3_R5" : "R4_R5");
        run_case(idx, bit'(d), 64'h0000_0000_0000_00A5, 64'd1, (4 << idx) + 6,
                 d ? "R2_R3_R5" : "R4_R5");
      end
    end

    // R6: large steps jump over several transitions
    run_case(1, 1'b1, 64'd0, 64'd11, 40, "R6");
    run_case(0, 1'b0, 64'd3, 64'd7, 40, "R6");
    run_case(4, 1'b1, 64'd100, 64'd53, 40, "R6");

    // top bit: rising transition reachable, falling one past the range
    run_case(63, 1'b1, 64'h7FFF_FFFF_FFFF_FFF8, 64'd1, 16, "R2");
    run_case(63, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 15, "R10");
    run_case(63, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 15, "R10");

    // R8: change the index at the moment the old target is reached
    @(negedge clk); en = 1'b0; sel = 6'd0; dir = 1'b1; cnt = 64'd0;
    @(negedge clk); en = 1'b1;
    @(negedge clk); chk(evt, 1'b0, "R7");
    cnt = 64'd1; sel = 6'd2;          // old target 1 reached, new target 4
    @(negedge clk); chk(evt, 1'b0, "R8");
    cnt = 64'd3;
    @(negedge clk); chk(evt, 1'b0, "R8");
    cnt = 64'd4;
    @(negedge clk); chk(evt, 1'b1, "R8");
    cnt = 64'd5; dir = 1'b0;          // direction change: new target 8
    @(negedge clk); chk(evt, 1'b0, "R8");
    cnt = 64'd8;
    @(negedge clk); chk(evt, 1'b1, "R8");

    // R9: disabled while the watched bit toggles
    en = 1'b0; sel = 6'd0; dir = 1'b1;
    for (int k = 0; k < 20; k++) begin
      cnt = cnt + 64'd1;
      @(negedge clk); chk(evt, 1'b0, "R9");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule